// File: doc/BRIEF.md
# Complementary Gate Driver with Dead-Time Insertion and Trip

The block turns one pulse-width phase signal into a high-side and a low-side gate drive for one inverter leg. Every transition of the phase input first switches both gate drives off. The drive that matches the new phase level turns on only after a programmable blanking interval. This interval keeps the two transistors of the leg from conducting at the same time. The blanking length is a 4-bit period multiplied by a power-of-two clock divider. The period is counted by an 8-bit counter that restarts whenever the phase input changes.

A separate trip input covers over-current protection. The trip input removes the output-enables of both drives through a purely combinational path, so the pads go high impedance without waiting for a clock edge. The same input is also synchronised into the clock domain and sets a sticky trip flag. The flag keeps both drives disabled until it is cleared. When blanking is switched off, the drives are the phase input and its exact complement.

The control is a three-state machine:
- `ST_LOW_ON`: the low-side drive is on.
- `ST_BLANK`: both drives are off.
- `ST_HIGH_ON`: the high-side drive is on.

Its transitions are named as follows:
- *edge-blank*: any state to `ST_BLANK` on a sampled phase change with a non-zero period.
- *edge-swap*: a sampled phase change with a zero period goes straight to the state of the new level.
- *blank-expire*: `ST_BLANK` to the state of the current level when the blanking count completes.
- *bypass-follow*: while disabled, the state tracks the phase level.

Reset enters `ST_BLANK`.

Top module: `deadband_gen`

## Requirements
- R1: The high-side and low-side drives are never both high in the same cycle.
- R2: With blanking enabled and a non-zero period, a phase change sampled at a rising clock edge turns both drives off from that edge onward. The drive for the new level turns on exactly period × divider clock cycles after that edge.
- R3: The divider code `dead_prescale_i` selects a divider of 2^code for codes 0 to 5, that is 1, 2, 4, 8, 16 or 32. Codes 6 and 7 both select 32.
- R4: A phase change sampled while blanking is in progress restarts the full blanking interval from that edge, and both drives stay off.
- R5: With a period of 0, a phase change swaps the drives at the sampled edge with no cycle in which both drives are off.
- R6: While `db_en_i` is low, `gate_hi_o` equals `phase_i` and `gate_lo_o` equals its inverse, with no clock delay. Raising `db_en_i` afterwards starts no blanking interval unless the phase changes.
- R7: While `trip_i` is high, both output-enables are low at once, without any clock edge.
- R8: `trip_flag_o` rises at the second rising edge after `trip_i` is sampled high. It holds both output-enables low and stays set until `trip_clear_i` is sampled high while the synchronised trip is low. A trip that is still active wins over a clear.
- R9: During and after reset, both drives are low, the output-enables are high and the flag is clear. A full blanking interval for a low phase level runs before the first drive turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | Phase (PWM) input |
| db_en_i | input | 1 | Blanking enable; low gives straight complementary outputs |
| dead_period_i | input | 4 | Blanking length in divided clock ticks |
| dead_prescale_i | input | 3 | Divider code, 2^code, codes 6 and 7 give 32 |
| trip_i | input | 1 | Asynchronous trip, active high |
| trip_clear_i | input | 1 | Clears the trip flag |
| gate_hi_o | output | 1 | High-side drive |
| gate_hi_oe_o | output | 1 | High-side output-enable |
| gate_lo_o | output | 1 | Low-side drive |
| gate_lo_oe_o | output | 1 | Low-side output-enable |
| trip_flag_o | output | 1 | Sticky trip flag |

## Verification
The drives change one rising edge after a phase change is sampled. The new drive turns on period × divider edges after that. The trip flag follows the trip input by two edges. The output-enables and the bypassed drives respond within the same half cycle with no edge at all.

The bench drives inputs just after a falling edge and advances a behavioural model on each rising edge from the sampled inputs. It compares every output on the following falling edge, so each due cycle is checked exactly where it falls. The asynchronous trip is checked half a nanosecond after it is applied, before any rising edge.

// File: rtl/db_pkg.sv
`timescale 1ns/1ps
package db_pkg;
    typedef enum logic [1:0] {
        ST_LOW_ON  = 2'd0,
        ST_BLANK   = 2'd1,
        ST_HIGH_ON = 2'd2
    } db_state_e;
endpackage

// File: rtl/db_timer.sv
`timescale 1ns/1ps
// Blanking timer: divider followed by a tick counter, restarted on demand.
module db_timer #(
    parameter int PER_W    = 4,
    parameter int PRE_W    = 3,
    parameter int CNT_W    = 8,
    parameter int DIV_LOG2 = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic             done_o
);
    localparam int PCNT_W = DIV_LOG2;

    logic [PCNT_W-1:0] pre_q;
    logic [PCNT_W-1:0] pre_lim;
    logic [PCNT_W:0]   one_sh;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W:0]    cnt_inc;
    logic              tick;

    assign one_sh = (PCNT_W+1)'(1) << presc_i;

    always_comb begin
        if (presc_i >= PRE_W'(DIV_LOG2)) begin
            pre_lim = '1;
        end else begin
            pre_lim = PCNT_W'(one_sh - (PCNT_W+1)'(1));
        end
    end

    assign tick    = (pre_q == pre_lim);
    assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign done_o  = (period_i == '0) ||
                     (tick && (cnt_inc >= (CNT_W+1)'(period_i)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (restart_i) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (run_i) begin
            if (tick) begin
                pre_q <= '0;
                if (cnt_q != '1) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else begin
                pre_q <= pre_q + PCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/db_fsm.sv
`timescale 1ns/1ps
// Drive state machine: low-on, blank, high-on.
module db_fsm
    import db_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      en_i,
    input  logic      edge_i,
    input  logic      phase_i,
    input  logic      phase_q_i,
    input  logic      zero_per_i,
    input  logic      done_i,
    output db_state_e state_o,
    output logic      hi_o,
    output logic      lo_o
);
    db_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = phase_i ? ST_HIGH_ON : ST_LOW_ON;        // bypass-follow
        end else if (edge_i) begin
            if (zero_per_i) begin
                state_d = phase_i ? ST_HIGH_ON : ST_LOW_ON;    // edge-swap
            end else begin
                state_d = ST_BLANK;                            // edge-blank
            end
        end else begin
            unique case (state_q)
                ST_BLANK: begin
                    if (done_i) begin
                        state_d = phase_q_i ? ST_HIGH_ON : ST_LOW_ON; // blank-expire
                    end
                end
                ST_LOW_ON, ST_HIGH_ON: begin
                    state_d = state_q;
                end
                default: state_d = ST_BLANK;
            endcase
        end
    end

    // outputs
    always_comb begin
        if (en_i) begin
            hi_o = (state_q == ST_HIGH_ON);
            lo_o = (state_q == ST_LOW_ON);
        end else begin
            hi_o = phase_i;
            lo_o = ~phase_i;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/db_trip.sv
`timescale 1ns/1ps
// Trip handling: combinational output-enable kill plus synchronised sticky flag.
module db_trip #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trip_i,
    input  logic clear_i,
    output logic flag_o,
    output logic oe_o
);
    logic sync_last;
    logic flag_q;

    if (SYNC_STAGES == 1) begin : g_sync_single
        logic sync_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= 1'b0;
            else         sync_q <= trip_i;
        end
        assign sync_last = sync_q;
    end else begin : g_sync_chain
        logic [SYNC_STAGES-1:0] sync_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= {sync_q[SYNC_STAGES-2:0], trip_i};
        end
        assign sync_last = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= sync_last | (flag_q & ~clear_i);
    end

    assign flag_o = flag_q;
    assign oe_o   = ~(trip_i | flag_q);
endmodule

// File: rtl/deadband_gen.sv
`timescale 1ns/1ps
module deadband_gen
    import db_pkg::*;
#(
    parameter int PER_W       = 4,
    parameter int PRE_W       = 3,
    parameter int CNT_W       = 8,
    parameter int DIV_LOG2    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             phase_i,
    input  logic             db_en_i,
    input  logic [PER_W-1:0] dead_period_i,
    input  logic [PRE_W-1:0] dead_prescale_i,
    input  logic             trip_i,
    input  logic             trip_clear_i,
    output logic             gate_hi_o,
    output logic             gate_hi_oe_o,
    output logic             gate_lo_o,
    output logic             gate_lo_oe_o,
    output logic             trip_flag_o
);
    logic      phase_q;
    logic      phase_edge;
    logic      blank_done;
    logic      oe;
    db_state_e state;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= 1'b0;
        else         phase_q <= phase_i;
    end

    assign phase_edge = phase_i ^ phase_q;

    db_timer #(
        .PER_W    (PER_W),
        .PRE_W    (PRE_W),
        .CNT_W    (CNT_W),
        .DIV_LOG2 (DIV_LOG2)
    ) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (phase_edge | ~db_en_i),
        .run_i     (state == ST_BLANK),
        .period_i  (dead_period_i),
        .presc_i   (dead_prescale_i),
        .done_o    (blank_done)
    );

    db_fsm i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (db_en_i),
        .edge_i     (phase_edge),
        .phase_i    (phase_i),
        .phase_q_i  (phase_q),
        .zero_per_i (dead_period_i == '0),
        .done_i     (blank_done),
        .state_o    (state),
        .hi_o       (gate_hi_o),
        .lo_o       (gate_lo_o)
    );

    db_trip #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_trip (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trip_i  (trip_i),
        .clear_i (trip_clear_i),
        .flag_o  (trip_flag_o),
        .oe_o    (oe)
    );

    assign gate_hi_oe_o = oe;
    assign gate_lo_oe_o = oe;
endmodule

// File: rtl/db_checker.sv
`timescale 1ns/1ps
module db_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       phase_i,
    input logic       db_en_i,
    input logic [3:0] dead_period_i,
    input logic       trip_i,
    input logic       trip_clear_i,
    input logic       gate_hi_o,
    input logic       gate_hi_oe_o,
    input logic       gate_lo_o,
    input logic       gate_lo_oe_o,
    input logic       trip_flag_o
);
    logic past_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(gate_hi_o && gate_lo_o)); // R1

    AST_EDGE_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && db_en_i && $past(db_en_i) && (phase_i != $past(phase_i)) && (dead_period_i != 4'd0))
        |=> (!db_en_i || (!gate_hi_o && !gate_lo_o))); // R2

    AST_BYPASS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !db_en_i |-> (gate_hi_o == phase_i) && (gate_lo_o == !phase_i)); // R6

    AST_TRIP_KILLS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip_i |-> (!gate_hi_oe_o && !gate_lo_oe_o)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trip_flag_o && !trip_clear_i) |=> trip_flag_o); // R8

    AST_FLAG_KILLS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip_flag_o |-> (!gate_hi_oe_o && !gate_lo_oe_o)); // R8
endmodule

bind deadband_gen db_checker i_db_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .phase_i       (phase_i),
    .db_en_i       (db_en_i),
    .dead_period_i (dead_period_i),
    .trip_i        (trip_i),
    .trip_clear_i  (trip_clear_i),
    .gate_hi_o     (gate_hi_o),
    .gate_hi_oe_o  (gate_hi_oe_o),
    .gate_lo_o     (gate_lo_o),
    .gate_lo_oe_o  (gate_lo_oe_o),
    .trip_flag_o   (trip_flag_o)
);

// File: tb/test_deadband_gen.sv
`timescale 1ns/1ps
module test_deadband_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase = 1'b0;
    logic       en = 1'b1;
    logic [3:0] per = 4'd3;
    logic [2:0] pre = 3'd0;
    logic       trip = 1'b0;
    logic       clr = 1'b0;
    logic       hi, hi_oe, lo, lo_oe, flag;

    int    checks = 0;
    int    errors = 0;
    string req = "R9";
    bit    checking = 1'b1;

    // reference model state
    bit m_dead  = 1'b1;
    int m_rem   = 0;
    bit m_level = 1'b0;
    bit m_prev  = 1'b0;
    bit m_s1 = 1'b0, m_s2 = 1'b0, m_flag = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    deadband_gen i_deadband_gen (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .phase_i         (phase),
        .db_en_i         (en),
        .dead_period_i   (per),
        .dead_prescale_i (pre),
        .trip_i          (trip),
        .trip_clear_i    (clr),
        .gate_hi_o       (hi),
        .gate_hi_oe_o    (hi_oe),
        .gate_lo_o       (lo),
        .gate_lo_oe_o    (lo_oe),
        .trip_flag_o     (flag)
    );

    function automatic int blank_len();
        int div;
        div = (pre >= 3'd5) ? 32 : (1 << pre);   // R3 divider encoding
        return int'(per) * div;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dead = 1'b1; m_level = 1'b0; m_prev = 1'b0;
            m_rem = blank_len();
            m_s1 = 1'b0; m_s2 = 1'b0; m_flag = 1'b0;
        end else begin
            m_flag = m_s2 | (m_flag & !clr);
            m_s2   = m_s1;
            m_s1   = trip;
            if (!en) begin
                m_dead = 1'b0; m_level = phase;
            end else if (phase != m_prev) begin
                m_level = phase;
                if (blank_len() == 0) m_dead = 1'b0;
                else begin m_dead = 1'b1; m_rem = blank_len(); end
            end else if (m_dead) begin
                if (m_rem <= 1) m_dead = 1'b0;
                else m_rem = m_rem - 1;
            end
            m_prev = phase;
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            chk(req, "gate_hi", hi, en ? (!m_dead && m_level) : phase);
            chk(req, "gate_lo", lo, en ? (!m_dead && !m_level) : !phase);
            chk(req, "oe_hi", hi_oe, !(trip || m_flag));
            chk(req, "oe_lo", lo_oe, !(trip || m_flag));
            chk(req, "trip_flag", flag, m_flag);
            chk("R1", "no overlap", hi && lo, 1'b0);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        // R9 reset state and first blanking interval
        cyc(3);
        rst_n = 1'b1;
        cyc(20);
        // R2 basic blanking, divider 1
        req = "R2";
        phase = 1'b1; cyc(10);
        phase = 1'b0; cyc(10);
        // R3 divider codes
        req = "R3";
        pre = 3'd2; per = 4'd2;
        phase = 1'b1; cyc(12);
        phase = 1'b0; cyc(12);
        pre = 3'd7; per = 4'd1;
        phase = 1'b1; cyc(40);
        pre = 3'd5; per = 4'd15;
        phase = 1'b0; cyc(500);
        // R4 retrigger inside the blanking interval
        req = "R4";
        pre = 3'd0; per = 4'd6;
        phase = 1'b1; cyc(3);
        phase = 1'b0; cyc(2);
        phase = 1'b1; cyc(10);
        // R5 zero period swaps directly
        req = "R5";
        per = 4'd0;
        for (int i = 0; i < 4; i++) begin
            phase = ~phase; cyc(3);
        end
        // R6 bypass then re-enable
        req = "R6";
        per = 4'd4; en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            phase = ~phase; cyc(1);
        end
        en = 1'b1; cyc(8);
        phase = ~phase; cyc(8);
        // R7 asynchronous output-enable kill, checked before any rising edge
        req = "R7";
        trip = 1'b1;
        #0.5;
        chk("R7", "oe_hi without clock", hi_oe, 1'b0);
        chk("R7", "oe_lo without clock", lo_oe, 1'b0);
        cyc(4);
        // R8 sticky flag, clear while trip active loses
        req = "R8";
        clr = 1'b1; cyc(3);
        clr = 1'b0; trip = 1'b0; cyc(4);
        clr = 1'b1; cyc(1);
        clr = 1'b0; cyc(4);
        checking = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule